// File: doc/BRIEF.md
# Serial ADC Conversion Read Controller

This block sits on the host side of a three-wire link to a delta-sigma converter: an active-low chip select, a serial clock and the converter's data output. The converter announces a finished conversion in-band. While the controller holds chip select low, the converter pulls its data line low. The controller synchronises that line, catches the falling edge, and then generates serial clock pulses from a divided system clock. It samples each bit on the serial clock rising edge.

A frame is a run of zero padding bits followed by the result, most significant bit first. The controller drops the padding, flags any padding bit that is not zero, and presents the result word with a one-cycle valid strobe while chip select is briefly raised. A timer started by each data-ready pulses a select-advance output for an external input multiplexer after a fixed number of serial clock periods. A separate counter raises a timeout when no data-ready arrives within a bound set by the converter's word period. A sleep request parks the serial clock high between frames, which the converter treats as a power-down command.

Top module: `adc_frame_reader`

## Requirements
- R1: During reset, cs_n_o, sclk_o, valid_o, mux_adv_o, frame_err_o and timeout_o are all low and data_o is zero.
- R2: A read starts only on a high-to-low transition of sdo_i seen while chip select is low. The sdo_i input passes through two synchroniser flops and an edge-detect flop, so the read starts on the third rising clock edge after sdo_i falls. sclk_o first goes high DIV cycles after that edge.
- R3: During a read, sclk_o is low for DIV cycles and then high for DIV cycles, for PAD_BITS+DATA_BITS periods. It is low outside reads and outside sleep.
- R4: Bits are taken at each sclk_o rising edge. The first PAD_BITS bits are dropped. The remaining DATA_BITS bits form data_o, with the first received bit as its MSB. data_o holds its value until the next result.
- R5: valid_o is high for exactly one cycle per completed frame. That cycle starts on the edge that ends the last serial clock high phase.
- R6: cs_n_o is low while waiting for data-ready and while reading. It is high for exactly the one cycle in which valid_o is high, and throughout sleep.
- R7: A 1 sampled at any padding position sets frame_err_o, which stays set until err_clr_i is sampled high. Clear takes priority over set, and the flag is low in the cycle after the clear is sampled.
- R8: When sleep_req_i is sampled high while waiting, sclk_o and cs_n_o go high on the next cycle. They stay high until the edge after sleep_req_i is sampled low. A request made during a read takes effect only after that frame completes.
- R9: mux_adv_o is high for one cycle, MUX_PERIODS*2*DIV clock edges after the edge on which a read starts. A new read start restarts the timer.
- R10: timeout_o rises after 3*612*SYS_PER_OSC consecutive idle-wait cycles with no data-ready. It falls when a read starts or sleep is entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdo_i | input | 1 | Converter serial data out; high when not driven |
| sleep_req_i | input | 1 | Request to park the serial clock high between frames |
| err_clr_i | input | 1 | Synchronous clear of the frame-error flag |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| data_o | output | DATA_BITS | Last result word |
| valid_o | output | 1 | One-cycle strobe marking a new data_o |
| mux_adv_o | output | 1 | One-cycle input multiplexer advance pulse |
| frame_err_o | output | 1 | Sticky flag: nonzero bit seen in the padding |
| timeout_o | output | 1 | No data-ready within the allowed wait |

## Verification
The assertions assume a sleep request is honoured only from the idle wait, and that err_clr_i is a synchronous pulse. The sleep-state assertion therefore traces a parked serial clock back to a request sampled on the previous edge. The bench converter model changes its data line only on the cycle after it sees a serial clock fall. It keeps the line high whenever chip select is high. It holds the first padding bit at zero, so the falling edge that marks data-ready is never mistaken for data. With DIV at four, each bit has two settled cycles behind the synchroniser before the sampling edge. Sleep requests are applied both while idle and in the middle of a frame, to exercise the deferred case.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV           = 4,
  parameter int PAD_BITS      = 8,
  parameter int DATA_BITS     = 16,
  parameter int MUX_PERIODS   = 595,
  parameter int OSC_RATIO     = 612,
  parameter int SYS_PER_OSC   = 2,
  parameter int WORDS_ALLOWED = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sdo_i,
  input  logic                 sleep_req_i,
  input  logic                 err_clr_i,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 mux_adv_o,
  output logic                 frame_err_o,
  output logic                 timeout_o
);

  localparam int FRAME    = PAD_BITS + DATA_BITS;
  localparam int BIT_W    = $clog2(FRAME + 1);
  localparam int PH_W     = $clog2(DIV);
  localparam int MUX_CYC  = MUX_PERIODS * 2 * DIV;
  localparam int MUX_W    = $clog2(MUX_CYC + 1);
  localparam int WAIT_LIM = WORDS_ALLOWED * OSC_RATIO * SYS_PER_OSC;
  localparam int WAIT_W   = $clog2(WAIT_LIM + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  typedef enum logic [1:0] {ST_WAIT, ST_READ, ST_DONE, ST_SLEEP} state_t;

  state_t                st;
  logic [2:0]            sync_q;
  logic [PH_W-1:0]       ph;
  logic                  sck;
  logic [BIT_W-1:0]      nbit;
  logic [DATA_BITS-1:0]  shreg;
  logic [MUX_W-1:0]      mux_cnt;
  logic                  mux_run;
  logic [WAIT_W-1:0]     wait_cnt;

  wire smp      = sync_q[1];
  wire ready    = sync_q[2] & ~sync_q[1];
  wire start    = (st == ST_WAIT) && !sleep_req_i && ready;
  wire rise_now = (st == ST_READ) && (ph == PH_LAST) && !sck;

  assign cs_n_o    = (st == ST_DONE) || (st == ST_SLEEP);
  assign sclk_o    = ((st == ST_READ) && sck) || (st == ST_SLEEP);
  assign mux_adv_o = mux_run && (mux_cnt == MUX_W'(MUX_CYC));
  assign timeout_o = (wait_cnt == WAIT_W'(WAIT_LIM));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], sdo_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_WAIT;
      ph      <= '0;
      sck     <= 1'b0;
      nbit    <= '0;
      shreg   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (st)
        ST_WAIT:
          if (sleep_req_i) st <= ST_SLEEP;
          else if (ready) begin
            st   <= ST_READ;
            ph   <= '0;
            sck  <= 1'b0;
            nbit <= '0;
          end
        ST_READ:
          if (ph == PH_LAST) begin
            ph  <= '0;
            sck <= ~sck;
            if (!sck) begin
              shreg <= {shreg[DATA_BITS-2:0], smp};
              nbit  <= nbit + 1'b1;
            end else if (nbit == BIT_W'(FRAME)) begin
              st      <= ST_DONE;
              valid_o <= 1'b1;
              data_o  <= shreg;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        ST_DONE:  st <= ST_WAIT;
        ST_SLEEP: if (!sleep_req_i) st <= ST_WAIT;
        default:  st <= ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) frame_err_o <= 1'b0;
    else if (err_clr_i) frame_err_o <= 1'b0;
    else if (rise_now && (nbit < BIT_W'(PAD_BITS)) && smp) frame_err_o <= 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_run <= 1'b0;
      mux_cnt <= '0;
    end else if (start) begin
      mux_run <= 1'b1;
      mux_cnt <= '0;
    end else if (mux_run) begin
      if (mux_cnt == MUX_W'(MUX_CYC)) mux_run <= 1'b0;
      else mux_cnt <= mux_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wait_cnt <= '0;
    else if (st != ST_WAIT || sleep_req_i || ready) wait_cnt <= '0;
    else if (!timeout_o) wait_cnt <= wait_cnt + 1'b1;

endmodule

module adc_frame_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_req_i,
  input logic err_clr_i,
  input logic cs_n_o,
  input logic sclk_o,
  input logic valid_o,
  input logic mux_adv_o,
  input logic frame_err_o,
  input logic timeout_o
);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R6
  valid_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (cs_n_o && !sclk_o));

  // R6
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && !sclk_o) |=> !cs_n_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err_o && !err_clr_i) |=> frame_err_o);

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_i |=> !frame_err_o);

  // R8
  sleep_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && sclk_o) |-> $past(sleep_req_i));

  // R9
  mux_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_adv_o |=> !mux_adv_o);

  // R10
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!cs_n_o && !sclk_o));

endmodule

bind adc_frame_reader adc_frame_reader_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_req_i (sleep_req_i),
  .err_clr_i   (err_clr_i),
  .cs_n_o      (cs_n_o),
  .sclk_o      (sclk_o),
  .valid_o     (valid_o),
  .mux_adv_o   (mux_adv_o),
  .frame_err_o (frame_err_o),
  .timeout_o   (timeout_o)
);

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int PAD   = 8;
  localparam int DATA  = 16;
  localparam int FRAME = PAD + DATA;
  localparam int MUXP  = 595;
  localparam int MUXC  = MUXP * 2 * DIV;
  localparam int SPO   = 2;
  localparam int WLIM  = 3 * 612 * SPO;

  logic clk = 1'b0, rst_n = 1'b0, sdo_i = 1'b1, sleep_req = 1'b0, err_clr = 1'b0;
  logic cs_n_o, sclk_o, valid_o, mux_adv_o, frame_err_o, timeout_o;
  logic [DATA-1:0] data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_reader #(.DIV(DIV), .PAD_BITS(PAD), .DATA_BITS(DATA), .MUX_PERIODS(MUXP),
                     .OSC_RATIO(612), .SYS_PER_OSC(SPO), .WORDS_ALLOWED(3)) i_adc_frame_reader (
    .clk(clk), .rst_n(rst_n), .sdo_i(sdo_i), .sleep_req_i(sleep_req), .err_clr_i(err_clr),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .data_o(data_o), .valid_o(valid_o),
    .mux_adv_o(mux_adv_o), .frame_err_o(frame_err_o), .timeout_o(timeout_o));

  int checks = 0, errors = 0, c_checks = 0, c_errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model, advanced on every rising edge
  int mode = 0, e = 0, mux_t = -1, wcnt = 0, p_data = 0;
  bit m1 = 1, m2 = 1, m3 = 1, p_err = 0, p_valid = 0, started = 0;
  bit q[$];

  always @(posedge clk) begin
    bit fl, sm, st, set_err;
    int old, d;
    if (!rst_n) begin
      mode = 0; e = 0; mux_t = -1; wcnt = 0; p_data = 0;
      m1 = 1; m2 = 1; m3 = 1; p_err = 0; p_valid = 0;
      q.delete();
    end else begin
      fl = m3 && !m2; sm = m2; old = mode; set_err = 0; p_valid = 0;
      st = (mode == 0) && !sleep_req && fl;
      case (mode)
        0: if (sleep_req) mode = 3; else if (fl) begin mode = 1; e = 0; q.delete(); end
        1: begin
          if (e % DIV == DIV - 1 && (e / DIV) % 2 == 0) begin
            if (q.size() < PAD && sm) set_err = 1;
            q.push_back(sm);
          end
          if (e == 2 * DIV * FRAME - 1) begin
            mode = 2; p_valid = 1; d = 0;
            for (int i = PAD; i < FRAME; i++) d = d * 2 + int'(q[i]);
            p_data = d;
          end else e++;
        end
        2: mode = 0;
        default: if (!sleep_req) mode = 0;
      endcase
      if (err_clr) p_err = 0; else if (set_err) p_err = 1;
      if (st) mux_t = 0; else if (mux_t >= 0) mux_t = (mux_t == MUXC) ? -1 : mux_t + 1;
      if (old == 0) begin
        if (fl || sleep_req) wcnt = 0; else if (wcnt < WLIM) wcnt++;
      end else wcnt = 0;
      m3 = m2; m2 = m1; m1 = sdo_i;
    end
    started = 1;
  end

  // converter model and per-cycle comparison, on falling edges
  int ncyc = 0, idx = -1, t0 = -1000000, post_id = 0, taken_id = 0, mux_seen = 0;
  bit line = 1, psclk = 0, pcs = 0, rarm = 0;
  logic [FRAME-1:0] pend_w = '0, frm = '0;

  task automatic chk_c(input string req, input int act, input int exp);
    c_checks++;
    if (act != exp) begin
      c_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit nv;
    ncyc++;
    if (started) begin
      chk_c("R6 cs_n", int'(cs_n_o), int'(mode == 2 || mode == 3));
      chk_c("R3 sclk", int'(sclk_o), int'((mode == 1 && (e / DIV) % 2 == 1) || mode == 3));
      chk_c("R5 valid", int'(valid_o), int'(p_valid));
      chk_c("R4 data", int'(data_o), p_data);
      chk_c("R9 mux", int'(mux_adv_o), int'(mux_t == MUXC));
      chk_c("R7 frame_err", int'(frame_err_o), int'(p_err));
      chk_c("R10 timeout", int'(timeout_o), int'(wcnt == WLIM));
    end
    if (rarm && sclk_o && !psclk && !cs_n_o) begin
      chk_c("R2 first sclk rise delay", ncyc - t0, 3 + DIV);
      rarm = 0;
    end
    if (mux_adv_o) begin
      mux_seen++;
      chk_c("R9 mux delay", ncyc - t0, MUXC + 3);
    end
    if (idx >= 0 && psclk && !sclk_o && !pcs) begin
      idx++;
      if (idx == FRAME) begin idx = -1; line = 1; end
      else line = frm[FRAME-1-idx];
    end
    if (post_id != taken_id && idx < 0) begin
      frm = pend_w; idx = 0; line = frm[FRAME-1]; taken_id = post_id;
    end
    nv = cs_n_o ? 1'b1 : line;
    if (sdo_i && !nv && idx == 0) begin t0 = ncyc; rarm = 1; end
    sdo_i = nv; psclk = sclk_o; pcs = cs_n_o;
  end

  task automatic post(input logic [DATA-1:0] w, input logic [PAD-1:0] pad);
    @(posedge clk);
    pend_w = {pad, w};
    post_id++;
  endtask

  task automatic wait_word(input logic [DATA-1:0] w, input string tag);
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!valid_o && n < 8000);
    chk(tag, valid_o ? int'(data_o) : -1, int'(w));
  endtask

  task automatic send(input logic [DATA-1:0] w, input logic [PAD-1:0] pad, input string tag);
    post(w, pad);
    wait_word(w, tag);
    repeat (30) @(negedge clk);
  endtask

  initial begin
    int ms;
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 reset cs_n", int'(cs_n_o), 0);
        chk("R1 reset sclk", int'(sclk_o), 0);
        chk("R1 reset valid", int'(valid_o), 0);
        chk("R1 reset data", int'(data_o), 0);
        chk("R1 reset mux", int'(mux_adv_o), 0);
        chk("R1 reset err", int'(frame_err_o), 0);
        chk("R1 reset timeout", int'(timeout_o), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R2 no clock without ready", int'(sclk_o), 0);

        send(16'hA5C3, 8'h00, "R4 word A5C3");
        send(16'h0000, 8'h00, "R4 word 0000");
        send(16'hFFFF, 8'h00, "R4 word FFFF");
        send(16'h8001, 8'h00, "R4 word 8001");
        send(16'h1234, 8'h00, "R4 word 1234");
        chk("R7 no error on clean padding", int'(frame_err_o), 0);

        send(16'h5A5A, 8'h10, "R7 word with bad padding");
        chk("R7 flag set", int'(frame_err_o), 1);
        send(16'h0F0F, 8'h00, "R7 word after error");
        chk("R7 flag sticky", int'(frame_err_o), 1);
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        chk("R7 flag cleared", int'(frame_err_o), 0);

        @(negedge clk) sleep_req = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 sclk parked high", int'(sclk_o), 1);
        chk("R8 cs high in sleep", int'(cs_n_o), 1);
        post(16'hC0DE, 8'h00);
        repeat (40) @(negedge clk);
        chk("R8 no read while asleep", int'(sclk_o && cs_n_o && !valid_o), 1);
        sleep_req = 1'b0;
        @(negedge clk);
        chk("R8 wake returns sclk low", int'(sclk_o), 0);
        wait_word(16'hC0DE, "R8 word after wake");
        repeat (30) @(negedge clk);

        post(16'h3C96, 8'h00);
        ms = 0;
        do begin @(negedge clk); ms++; end while (!sclk_o && ms < 2000);
        sleep_req = 1'b1;
        wait_word(16'h3C96, "R8 request during read deferred");
        repeat (3) @(negedge clk);
        chk("R8 sleep after frame", int'(sclk_o && cs_n_o), 1);
        sleep_req = 1'b0;
        repeat (30) @(negedge clk);

        ms = mux_seen;
        send(16'h7E81, 8'h00, "R9 word before mux wait");
        repeat (MUXC + 20) @(negedge clk);
        chk("R9 one pulse after idle", mux_seen - ms, 1);
        chk("R10 timeout raised", int'(timeout_o), 1);
        send(16'h2468, 8'h00, "R10 word after timeout");
        chk("R10 timeout cleared", int'(timeout_o), 0);
        repeat (10) @(negedge clk);
      end
      begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks + c_checks, errors + c_errors);
    $finish;
  end
endmodule